// File: doc/BRIEF.md
# Dual-Issue Out-of-Order Instruction Queue

This block is the scheduling window of an out-of-order core. After renaming, up to four instructions per cycle enter a small queue. Each entry holds two source physical register tags with a ready bit for each, a destination tag, a flag that picks the memory pipe or an ALU, and the entry's reorder-buffer index, which also serves as its age. The block tracks tags and ready bits only. Operand values, the register file and the execution units lie outside it.

Each cycle the queue grants up to two entries whose sources have both been produced and whose unit is free. The grants follow dataflow order, not program order, and the oldest eligible entries win. There are two ALUs and one memory pipe. An ALU result wakes its dependents in time to issue on the next cycle. A load spends two cycles in the memory pipe, so its dependents, and any further load, must wait one extra cycle. A flush port removes every entry younger than a given reorder-buffer index. When the queue has no room for a full group of four, insertion stalls.

Top module: `ooo_dual_issue_queue`

## Requirements
- R1: Once reset is released the queue is empty. No issue slot is valid and `ins_ready` is 1.
- R2: Lanes with `ins_valid` set in a cycle where `ins_ready` is 1 are written at that clock edge. An entry with both sources ready can be granted in the very next cycle.
- R3: An entry with a source whose ready bit is 0 is never granted until that tag has been produced by an instruction issued from the queue.
- R4: When an ALU instruction (`ins_mem`=0) issues in cycle c, an entry waiting on its destination tag can be granted in cycle c+1.
- R5: When a load (`ins_mem`=1) issues in cycle c, entries waiting on its destination tag are not granted before cycle c+2, and can be granted in c+2.
- R6: At most one memory entry is granted per cycle. In the cycle after a memory grant, no memory entry is granted. `iss_mem`=1 marks a memory-pipe grant.
- R7: At most two entries are granted per cycle. Any further eligible entries wait for a later cycle.
- R8: When more than two entries are eligible, the two with the lowest reorder-buffer index win. Slot 0 carries the older one, and slot 1 is valid only when slot 0 is.
- R9: A younger eligible entry is granted ahead of an older entry that is still waiting on operands.
- R10: While `flush_valid` is 1, every entry with a reorder-buffer index above `flush_rob` is removed at the edge and is not granted in that cycle. Lanes inserted in that cycle with an index above `flush_rob` are dropped.
- R11: `ins_ready` is 1 only while at least four slots are free. While it is 0, the insertion lanes are ignored. A slot freed by a grant counts as free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | LANES | Insertion lane valid |
| ins_src1 | input | LANES x TAGW | First source tag per lane |
| ins_src1_rdy | input | LANES | First source already produced |
| ins_src2 | input | LANES x TAGW | Second source tag per lane |
| ins_src2_rdy | input | LANES | Second source already produced |
| ins_dst | input | LANES x TAGW | Destination tag per lane |
| ins_mem | input | LANES | 1 = memory pipe (load), 0 = ALU |
| ins_rob | input | LANES x ROBW | Reorder-buffer index (age) per lane |
| ins_ready | output | 1 | Queue can take a full insertion group |
| flush_valid | input | 1 | Flush request |
| flush_rob | input | ROBW | Entries younger than this index are removed |
| iss_valid | output | 2 | Grant valid per issue slot |
| iss_mem | output | 2 | Grant targets the memory pipe |
| iss_dst | output | 2 x TAGW | Destination tag of each grant |
| iss_src1 | output | 2 x TAGW | First source tag of each grant |
| iss_src2 | output | 2 x TAGW | Second source tag of each grant |
| iss_rob | output | 2 x ROBW | Reorder-buffer index of each grant |

## Verification
Every result has a fixed due cycle, counted from the edge that captures the stimulus. A group inserted at an edge shows its ready members on the grant outputs during the next cycle. An ALU dependent is granted one cycle after its producer, and a load dependent, like the next load, two cycles after. A flush masks young grants combinationally in its own cycle, and `ins_ready` reflects slots freed by a grant from the cycle after that grant. The bench drives inputs at the falling edge and samples one nanosecond later, so each check reads exactly the cycle in which the requirement says the value is due, and every stalled or dropped instruction is checked for absence over the cycles where it would otherwise have appeared.

// File: rtl/ooo_dual_issue_queue.sv
module ooo_dual_issue_queue #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  parameter int TAGW  = 6,
  parameter int ROBW  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               ins_valid,
  input  logic [LANES-1:0][TAGW-1:0]     ins_src1,
  input  logic [LANES-1:0]               ins_src1_rdy,
  input  logic [LANES-1:0][TAGW-1:0]     ins_src2,
  input  logic [LANES-1:0]               ins_src2_rdy,
  input  logic [LANES-1:0][TAGW-1:0]     ins_dst,
  input  logic [LANES-1:0]               ins_mem,
  input  logic [LANES-1:0][ROBW-1:0]     ins_rob,
  output logic                           ins_ready,
  input  logic                           flush_valid,
  input  logic [ROBW-1:0]                flush_rob,
  output logic [1:0]                     iss_valid,
  output logic [1:0]                     iss_mem,
  output logic [1:0][TAGW-1:0]           iss_dst,
  output logic [1:0][TAGW-1:0]           iss_src1,
  output logic [1:0][TAGW-1:0]           iss_src2,
  output logic [1:0][ROBW-1:0]           iss_rob
);

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int LSEL = (LANES > 1) ? $clog2(LANES) : 1;

  logic [DEPTH-1:0] vld, r1, r2, is_mem;
  logic [TAGW-1:0]  s1 [DEPTH];
  logic [TAGW-1:0]  s2 [DEPTH];
  logic [TAGW-1:0]  dst [DEPTH];
  logic [ROBW-1:0]  rob [DEPTH];

  logic             ld_v;
  logic [TAGW-1:0]  ld_tag;

  logic [DEPTH-1:0] kill, ready, mem_cand, mem_pick, elig, sel0, sel1, take, wr;
  logic [CW-1:0]    rank [DEPTH];
  logic [CW-1:0]    lrank [LANES];
  logic [LSEL-1:0]  lane_of [DEPTH];
  logic [LANES-1:0] lane_drop;
  logic [CW-1:0]    nfree;

  always_comb
    for (int i = 0; i < DEPTH; i++)
      kill[i] = flush_valid && vld[i] && (rob[i] > flush_rob);

  assign ready    = vld & r1 & r2 & ~kill;
  assign mem_cand = ready & is_mem & {DEPTH{~ld_v}};

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      mem_pick[i] = mem_cand[i];
      for (int j = 0; j < DEPTH; j++)
        if (mem_cand[j] && rob[j] < rob[i]) mem_pick[i] = 1'b0;
    end

  assign elig = ready & (~is_mem | mem_pick);

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && elig[j] && rob[j] < rob[i]) rank[i] = rank[i] + CW'(1);
      sel0[i] = elig[i] && (rank[i] == '0);
      sel1[i] = elig[i] && (rank[i] == CW'(1));
    end

  always_comb begin
    iss_valid = {|sel1, |sel0};
    iss_mem   = '0;
    iss_dst   = '0;
    iss_src1  = '0;
    iss_src2  = '0;
    iss_rob   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel0[i]) begin
        iss_mem[0] = is_mem[i]; iss_dst[0] = dst[i];
        iss_src1[0] = s1[i]; iss_src2[0] = s2[i]; iss_rob[0] = rob[i];
      end
      if (sel1[i]) begin
        iss_mem[1] = is_mem[i]; iss_dst[1] = dst[i];
        iss_src1[1] = s1[i]; iss_src2[1] = s2[i]; iss_rob[1] = rob[i];
      end
    end
  end

  function automatic logic woke(input logic [TAGW-1:0] t);
    return (iss_valid[0] && !iss_mem[0] && t == iss_dst[0]) ||
           (iss_valid[1] && !iss_mem[1] && t == iss_dst[1]) ||
           (ld_v && t == ld_tag);
  endfunction

  always_comb begin
    lrank[0] = '0;
    for (int k = 1; k < LANES; k++)
      lrank[k] = lrank[k-1] + CW'(ins_valid[k-1]);
    for (int k = 0; k < LANES; k++)
      lane_drop[k] = flush_valid && (ins_rob[k] > flush_rob);
  end

  always_comb begin
    nfree = '0;
    take  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      lane_of[i] = '0;
      if (!vld[i]) begin
        for (int k = 0; k < LANES; k++)
          if (ins_valid[k] && lrank[k] == nfree) begin
            take[i]    = 1'b1;
            lane_of[i] = LSEL'(k);
          end
        nfree = nfree + CW'(1);
      end
    end
  end

  assign ins_ready = (nfree >= CW'(LANES));

  always_comb
    for (int i = 0; i < DEPTH; i++)
      wr[i] = take[i] && ins_ready && !lane_drop[lane_of[i]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      ld_v   <= 1'b0;
      ld_tag <= '0;
    end else begin
      ld_v   <= (iss_valid[0] && iss_mem[0]) || (iss_valid[1] && iss_mem[1]);
      ld_tag <= (iss_valid[0] && iss_mem[0]) ? iss_dst[0] : iss_dst[1];
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i] || sel0[i] || sel1[i]) begin
          vld[i] <= 1'b0;
        end else if (vld[i]) begin
          r1[i] <= r1[i] | woke(s1[i]);
          r2[i] <= r2[i] | woke(s2[i]);
        end else if (wr[i]) begin
          vld[i]    <= 1'b1;
          s1[i]     <= ins_src1[lane_of[i]];
          s2[i]     <= ins_src2[lane_of[i]];
          r1[i]     <= ins_src1_rdy[lane_of[i]] | woke(ins_src1[lane_of[i]]);
          r2[i]     <= ins_src2_rdy[lane_of[i]] | woke(ins_src2[lane_of[i]]);
          dst[i]    <= ins_dst[lane_of[i]];
          is_mem[i] <= ins_mem[lane_of[i]];
          rob[i]    <= ins_rob[lane_of[i]];
        end
      end
    end
  end

endmodule

// File: rtl/ooo_dual_issue_queue_checker.sv
module ooo_dual_issue_queue_checker #(
  parameter int ROBW = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush_valid,
  input logic [ROBW-1:0]            flush_rob,
  input logic [1:0]                 iss_valid,
  input logic [1:0]                 iss_mem,
  input logic [1:0][ROBW-1:0]       iss_rob
);

  logic mem_now;
  assign mem_now = (iss_valid[0] && iss_mem[0]) || (iss_valid[1] && iss_mem[1]);

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid == 2'b11 && iss_mem == 2'b11)); // R6

  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_now |=> !mem_now); // R6

  AST_SLOT_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> (iss_valid[0] && iss_rob[0] < iss_rob[1])); // R8

  AST_FLUSH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !(iss_valid[0] && iss_rob[0] > flush_rob) &&
                    !(iss_valid[1] && iss_rob[1] > flush_rob)); // R10

  AST_FLUSH_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> !(iss_valid[0] && iss_rob[0] > $past(flush_rob)) &&
                    !(iss_valid[1] && iss_rob[1] > $past(flush_rob))); // R10

endmodule

bind ooo_dual_issue_queue ooo_dual_issue_queue_checker #(.ROBW(ROBW)) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_valid (flush_valid),
  .flush_rob   (flush_rob),
  .iss_valid   (iss_valid),
  .iss_mem     (iss_mem),
  .iss_rob     (iss_rob)
);

// File: tb/test_ooo_dual_issue_queue.sv
module test_ooo_dual_issue_queue;
  localparam int DEPTH = 8;
  localparam int LANES = 4;
  localparam int TAGW  = 6;
  localparam int ROBW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0]           ins_valid = '0;
  logic [LANES-1:0][TAGW-1:0] ins_src1 = '0, ins_src2 = '0, ins_dst = '0;
  logic [LANES-1:0]           ins_src1_rdy = '0, ins_src2_rdy = '0, ins_mem = '0;
  logic [LANES-1:0][ROBW-1:0] ins_rob = '0;
  logic                       ins_ready;
  logic                       flush_valid = 1'b0;
  logic [ROBW-1:0]            flush_rob = '0;
  logic [1:0]                 iss_valid, iss_mem;
  logic [1:0][TAGW-1:0]       iss_dst, iss_src1, iss_src2;
  logic [1:0][ROBW-1:0]       iss_rob;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ooo_dual_issue_queue #(.DEPTH(DEPTH), .LANES(LANES), .TAGW(TAGW), .ROBW(ROBW)) i_ooo_dual_issue_queue (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy),
    .ins_src2(ins_src2), .ins_src2_rdy(ins_src2_rdy), .ins_dst(ins_dst),
    .ins_mem(ins_mem), .ins_rob(ins_rob), .ins_ready(ins_ready),
    .flush_valid(flush_valid), .flush_rob(flush_rob),
    .iss_valid(iss_valid), .iss_mem(iss_mem), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_rob(iss_rob)
  );

  task automatic put(input int k, input int a, input bit ar, input int b, input bit br,
                     input int d, input bit m, input int r);
    ins_valid[k]    = 1'b1;
    ins_src1[k]     = TAGW'(a);
    ins_src1_rdy[k] = ar;
    ins_src2[k]     = TAGW'(b);
    ins_src2_rdy[k] = br;
    ins_dst[k]      = TAGW'(d);
    ins_mem[k]      = m;
    ins_rob[k]      = ROBW'(r);
  endtask

  task automatic adv();
    @(negedge clk);
    ins_valid   = '0;
    flush_valid = 1'b0;
    flush_rob   = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ins_valid = '0;
    flush_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_iss(input string req, input logic [1:0] ev, input int e0, input int e1,
                           input logic [1:0] em);
    bit ok;
    #1;
    ok = (iss_valid == ev);
    if (ev[0] && (iss_rob[0] != ROBW'(e0) || iss_mem[0] != em[0])) ok = 1'b0;
    if (ev[1] && (iss_rob[1] != ROBW'(e1) || iss_mem[1] != em[1])) ok = 1'b0;
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: valid=%b rob0=%0d rob1=%0d mem=%b expected valid=%b rob0=%0d rob1=%0d mem=%b",
               req, iss_valid, iss_rob[0], iss_rob[1], iss_mem, ev, e0, e1, em);
    end
  endtask

  task automatic check_rdy(input string req, input logic exp);
    #1;
    n_tests++;
    if (ins_ready !== exp) begin
      n_fail++;
      $display("FAIL %s: ins_ready=%b expected %b", req, ins_ready, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_iss("R1", 2'b00, 0, 0, 2'b00);
    check_rdy("R1", 1'b1);
  endtask

  task automatic t_alu_chain();
    do_reset();
    put(0, 1, 1, 2, 1, 10, 0, 1);
    put(1, 10, 0, 2, 1, 11, 0, 2);
    put(2, 3, 1, 11, 0, 12, 0, 3);
    adv(); check_iss("R2", 2'b01, 1, 0, 2'b00);
    adv(); check_iss("R4", 2'b01, 2, 0, 2'b00);
    adv(); check_iss("R4", 2'b01, 3, 0, 2'b00);
    adv(); check_iss("R4", 2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_load();
    do_reset();
    put(0, 1, 1, 1, 1, 20, 1, 1);
    put(1, 1, 1, 1, 1, 21, 1, 2);
    put(2, 20, 0, 1, 1, 22, 0, 3);
    adv(); check_iss("R6", 2'b01, 1, 0, 2'b01);
    adv(); check_iss("R5", 2'b00, 0, 0, 2'b00);
    adv(); check_iss("R5", 2'b11, 2, 3, 2'b01);
    adv(); check_iss("R6", 2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_width();
    do_reset();
    put(0, 1, 1, 1, 1, 30, 0, 8);
    put(1, 1, 1, 1, 1, 31, 0, 6);
    put(2, 1, 1, 1, 1, 32, 0, 5);
    put(3, 1, 1, 1, 1, 33, 0, 7);
    adv(); check_iss("R7", 2'b11, 5, 6, 2'b00);
    adv(); check_iss("R8", 2'b11, 7, 8, 2'b00);
    adv(); check_iss("R7", 2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_dataflow();
    do_reset();
    put(0, 40, 0, 1, 1, 41, 0, 1);
    put(1, 1, 1, 1, 1, 42, 0, 2);
    adv(); check_iss("R9", 2'b01, 2, 0, 2'b00);
    adv(); check_iss("R3", 2'b00, 0, 0, 2'b00);
    adv(); check_iss("R3", 2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_flush();
    do_reset();
    put(0, 50, 0, 1, 1, 51, 0, 1);
    put(1, 50, 0, 1, 1, 52, 0, 2);
    put(2, 50, 0, 1, 1, 53, 0, 3);
    put(3, 1, 1, 1, 1, 54, 0, 4);
    adv();
    flush_valid = 1'b1;
    flush_rob   = ROBW'(2);
    put(0, 1, 1, 1, 1, 55, 0, 9);
    put(1, 1, 1, 1, 1, 56, 0, 0);
    check_iss("R10", 2'b00, 0, 0, 2'b00);
    adv();
    put(0, 1, 1, 1, 1, 50, 0, 5);
    check_iss("R10", 2'b01, 0, 0, 2'b00);
    adv(); check_iss("R4", 2'b01, 5, 0, 2'b00);
    adv(); check_iss("R10", 2'b11, 1, 2, 2'b00);
    adv(); check_iss("R10", 2'b00, 0, 0, 2'b00);
  endtask

  task automatic t_backpressure();
    do_reset();
    for (int k = 0; k < 4; k++) put(k, 60, 0, 1, 1, 61 + k, 0, 1 + k);
    adv();
    check_rdy("R11", 1'b1);
    put(0, 1, 1, 1, 1, 2, 0, 5);
    put(1, 1, 1, 1, 1, 3, 0, 6);
    put(2, 60, 0, 1, 1, 4, 0, 7);
    put(3, 60, 0, 1, 1, 5, 0, 8);
    adv();
    check_rdy("R11", 1'b0);
    check_iss("R2", 2'b11, 5, 6, 2'b00);
    put(0, 1, 1, 1, 1, 7, 0, 9);
    adv();
    check_rdy("R11", 1'b0);
    check_iss("R11", 2'b00, 0, 0, 2'b00);
    flush_valid = 1'b1;
    flush_rob   = ROBW'(6);
    adv();
    check_rdy("R11", 1'b1);
    check_iss("R11", 2'b00, 0, 0, 2'b00);
  endtask

  initial begin
    t_reset();
    t_alu_chain();
    t_load();
    t_width();
    t_dataflow();
    t_flush();
    t_backpressure();
    adv();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule